// File: doc/BRIEF.md
# Masked Content-Addressable Memory

The block is a searchable word store of 512 rows, each 64 bits wide. One command input picks the operation for each cycle. A row can be written or read by its 9-bit index. A search compares a stored key pattern against every row at once. A global mask register decides which bit positions take part in that comparison. Two further commands load the key and the mask from the shared data input.

A search returns three results: a per-row hit vector, a flag that is set when any row hit, and the index of the winning row. When several rows hit, the row with the lowest index wins. A row counts as empty from reset until it has been written once, and an empty row never hits. Search results are registered, and they stay on the outputs until the next search command. A combined command writes one row and searches in the same cycle. That search sees the row contents from before the write.

The command decoder is the centre of the block. Each cycle it takes one of these paths: IDLE, READ, WRITE, MATCH, LOAD_KEY, LOAD_MASK or WRITE_MATCH. Every path returns to the decision on the next cycle, and an unknown code follows the IDLE path.

Top module: `mcam_top`

## Requirements
- R1: A WRITE (cmd=2) stores data_in at row addr. A READ (cmd=1) of that row shows the stored word on rd_data one clock after the READ cycle. rd_data holds its value until the next READ.
- R2: A MATCH (cmd=3) compares only the bit positions where the mask register holds 1. Positions where the mask holds 0 always count as equal. A mask of all zeros therefore matches every written row.
- R3: One clock after a MATCH, bit r of hit_vec is 1 exactly when row r has been written and equals the key on every bit the mask enables.
- R4: One clock after a MATCH, hit_any is 1 exactly when at least one bit of hit_vec is 1.
- R5: hit_addr holds the lowest index whose hit_vec bit is 1, and it holds 0 when no row hits.
- R6: hit_vec, hit_any and hit_addr change only in the clock after a MATCH or WRITE_MATCH command. Every other command leaves them unchanged.
- R7: WRITE_MATCH (cmd=6) writes row addr and searches in the same cycle. The search uses the contents the row had before that write, and the new word is stored for later searches and reads.
- R8: After reset no row is written, the key is all zeros, the mask is all ones, and rd_data, hit_vec, hit_any and hit_addr are zero. A search before any write reports no hit.
- R9: LOAD_KEY (cmd=4) and LOAD_MASK (cmd=5) copy data_in into the key and mask registers. Later searches use these new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command: 0 idle, 1 read, 2 write, 3 match, 4 load key, 5 load mask, 6 write and match |
| addr | input | 9 | Row index for read and write |
| data_in | input | 64 | Write word, or value for key and mask loads |
| rd_data | output | 64 | Registered read word |
| hit_vec | output | 512 | Registered per-row hit indication |
| hit_any | output | 1 | Registered flag: at least one row hit |
| hit_addr | output | 9 | Registered index of the lowest hitting row |

## Verification
The assertions check several rules on every cycle:
- hit_any always agrees with hit_vec.
- The bit of hit_vec at hit_addr is set, and no lower bit is set.
- The search results stay still through non-search commands.
- Reads and writes move the right word.
- A search with no written rows reports no hit.

Only the bench scenarios can show the rest:
- That the masked compare finds the right rows for each key and mask pattern.
- That ties resolve to the lowest row.
- That a combined write and search sees the old row contents.
- That key and mask loads take effect.

// File: rtl/mcam_pkg.sv
package mcam_pkg;
    typedef enum logic [2:0] {
        OP_IDLE        = 3'd0,
        OP_READ        = 3'd1,
        OP_WRITE       = 3'd2,
        OP_MATCH       = 3'd3,
        OP_LOAD_KEY    = 3'd4,
        OP_LOAD_MASK   = 3'd5,
        OP_WRITE_MATCH = 3'd6
    } op_e;

    typedef struct packed {
        logic wr_en;
        logic rd_en;
        logic srch_en;
        logic key_ld;
        logic mask_ld;
    } ctl_t;
endpackage

// File: rtl/mcam_decode.sv
module mcam_decode
    import mcam_pkg::*;
(
    input  logic [2:0] cmd,
    output ctl_t       ctl
);
    op_e op;
    assign op = op_e'(cmd);

    always_comb begin
        ctl = '0;
        unique case (op)
            OP_READ:        ctl.rd_en   = 1'b1;
            OP_WRITE:       ctl.wr_en   = 1'b1;
            OP_MATCH:       ctl.srch_en = 1'b1;
            OP_LOAD_KEY:    ctl.key_ld  = 1'b1;
            OP_LOAD_MASK:   ctl.mask_ld = 1'b1;
            OP_WRITE_MATCH: begin
                ctl.wr_en   = 1'b1;
                ctl.srch_en = 1'b1;
            end
            default:        ctl = '0;
        endcase
    end
endmodule

// File: rtl/mcam_store.sv
module mcam_store #(
    parameter int ROWS  = 512,
    parameter int WIDTH = 64,
    localparam int AW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] rows_o [ROWS],
    output logic [ROWS-1:0]  filled_o
);
    logic [WIDTH-1:0] mem [ROWS];
    logic [ROWS-1:0]  filled_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filled_q <= '0;
            rd_data  <= '0;
        end else begin
            if (wr_en) filled_q[addr] <= 1'b1;
            if (rd_en) rd_data <= mem[addr];
        end
    end

    assign rows_o   = mem;
    assign filled_o = filled_q;

    // R1
    rd_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> (rd_data == $past(mem[addr])));

    // R1
    wr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (filled_q[$past(addr)] && mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/mcam_compare.sv
module mcam_compare #(
    parameter int ROWS  = 512,
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] rows_i [ROWS],
    input  logic [ROWS-1:0]  filled_i,
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] mask,
    output logic [ROWS-1:0]  hits
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign hits[r] = filled_i[r] && (((rows_i[r] ^ key) & mask) == '0);
    end
endmodule

// File: rtl/mcam_prio.sv
module mcam_prio #(
    parameter int ROWS = 512,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic [ROWS-1:0] req,
    output logic            any,
    output logic [AW-1:0]   idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (req[r]) begin
                any = 1'b1;
                idx = AW'(r);
            end
        end
    end
endmodule

// File: rtl/mcam_top.sv
module mcam_top
    import mcam_pkg::*;
#(
    parameter int ROWS  = 512,
    parameter int WIDTH = 64,
    localparam int AW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] rd_data,
    output logic [ROWS-1:0]  hit_vec,
    output logic             hit_any,
    output logic [AW-1:0]    hit_addr
);
    ctl_t             ctl;
    logic [WIDTH-1:0] key_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] rows [ROWS];
    logic [ROWS-1:0]  filled;
    logic [ROWS-1:0]  raw_hits;
    logic             raw_any;
    logic [AW-1:0]    raw_idx;

    mcam_decode u_dec (.cmd(cmd), .ctl(ctl));

    mcam_store #(.ROWS(ROWS), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl.wr_en), .rd_en(ctl.rd_en),
        .addr(addr), .wdata(data_in), .rd_data(rd_data),
        .rows_o(rows), .filled_o(filled)
    );

    mcam_compare #(.ROWS(ROWS), .WIDTH(WIDTH)) u_cmp (
        .rows_i(rows), .filled_i(filled), .key(key_q), .mask(mask_q),
        .hits(raw_hits)
    );

    mcam_prio #(.ROWS(ROWS)) u_prio (.req(raw_hits), .any(raw_any), .idx(raw_idx));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q    <= '0;
            mask_q   <= '1;
            hit_vec  <= '0;
            hit_any  <= 1'b0;
            hit_addr <= '0;
        end else begin
            if (ctl.key_ld)  key_q  <= data_in;
            if (ctl.mask_ld) mask_q <= data_in;
            if (ctl.srch_en) begin
                hit_vec  <= raw_hits;
                hit_any  <= raw_any;
                hit_addr <= raw_idx;
            end
        end
    end

    // R4
    any_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any == (hit_vec != '0));

    // R5
    winner_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> hit_vec[hit_addr]);

    // R5
    winner_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec & ((ROWS'(1) << hit_addr) - ROWS'(1))) == '0);

    // R5
    idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_any |-> (hit_addr == '0));

    // R6
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.srch_en |=> ($stable(hit_vec) && $stable(hit_any) && $stable(hit_addr)));

    // R8
    empty_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.srch_en && filled == '0) |=> !hit_any);

    // R3
    only_filled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.srch_en |=> ((hit_vec & ~$past(filled)) == '0));
endmodule

// File: tb/mcam_top_test.sv
module mcam_top_test;
    localparam int ROWS  = 512;
    localparam int WIDTH = 64;
    localparam int AW    = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cmd = 3'd0;
    logic [AW-1:0]    addr = '0;
    logic [WIDTH-1:0] data_in = '0;
    logic [WIDTH-1:0] rd_data;
    logic [ROWS-1:0]  hit_vec;
    logic             hit_any;
    logic [AW-1:0]    hit_addr;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mcam_top uut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .data_in(data_in),
        .rd_data(rd_data), .hit_vec(hit_vec), .hit_any(hit_any), .hit_addr(hit_addr)
    );

    typedef struct packed {
        logic [63:0] key;
        logic [63:0] mask;
        logic        any;
        logic [8:0]  win;
        logic [9:0]  cnt;
    } vec_t;

    // rows written: 5, 9, 300, 511 (see below)
    localparam vec_t TBL [8] = '{
        '{64'hDEAD_BEEF_0000_1111, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 9'd5,   10'd1},
        '{64'hDEAD_BEEF_0000_0000, 64'hFFFF_FFFF_0000_0000, 1'b1, 9'd5,   10'd2},
        '{64'h0000_0000_0000_2222, 64'h0000_0000_0000_FFFF, 1'b1, 9'd9,   10'd1},
        '{64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 9'd300, 10'd1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 9'd511, 10'd1},
        '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b1, 9'd5,   10'd4},
        '{64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 9'd0,   10'd0},
        '{64'h0000_0000_0000_CDEF, 64'h0000_0000_0000_FFFF, 1'b1, 9'd300, 10'd1}
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic [AW-1:0] a,
                         input logic [WIDTH-1:0] d);
        @(negedge clk);
        cmd = c; addr = a; data_in = d;
        @(negedge clk);
        cmd = 3'd0;
    endtask

    task automatic search(input logic [63:0] k, input logic [63:0] m);
        issue(3'd4, '0, k);
        issue(3'd5, '0, m);
        issue(3'd3, '0, '0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_run++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(rd_data == '0 && hit_vec == '0 && !hit_any && hit_addr == '0,
              "R8 reset outputs", {63'd0, hit_any}, 64'd0);
        issue(3'd3, '0, '0);   // reset key 0, mask all ones, no rows
        check(!hit_any && hit_vec == '0, "R8 empty search", {63'd0, hit_any}, 64'd0);

        issue(3'd2, 9'd5,   64'hDEAD_BEEF_0000_1111);
        issue(3'd2, 9'd9,   64'hDEAD_BEEF_0000_2222);
        issue(3'd2, 9'd300, 64'h0123_4567_89AB_CDEF);
        issue(3'd2, 9'd511, 64'hFFFF_FFFF_FFFF_FFFF);

        // R1 read back
        issue(3'd1, 9'd300, '0);
        check(rd_data == 64'h0123_4567_89AB_CDEF, "R1 read row 300", rd_data,
              64'h0123_4567_89AB_CDEF);
        issue(3'd1, 9'd9, '0);
        check(rd_data == 64'hDEAD_BEEF_0000_2222, "R1 read row 9", rd_data,
              64'hDEAD_BEEF_0000_2222);

        // R2 R3 R4 R5 R9 table walk
        for (int i = 0; i < 8; i++) begin
            search(TBL[i].key, TBL[i].mask);
            check(hit_any == TBL[i].any, $sformatf("R4 vec %0d any", i),
                  {63'd0, hit_any}, {63'd0, TBL[i].any});
            check(hit_addr == TBL[i].win, $sformatf("R5 vec %0d winner", i),
                  {55'd0, hit_addr}, {55'd0, TBL[i].win});
            check($countones(hit_vec) == int'(TBL[i].cnt), $sformatf("R3 R2 vec %0d count", i),
                  64'($countones(hit_vec)), {54'd0, TBL[i].cnt});
        end

        // R3 exact rows for the shared-prefix key
        search(64'hDEAD_BEEF_0000_0000, 64'hFFFF_FFFF_0000_0000);
        check(hit_vec[5] && hit_vec[9] && !hit_vec[300], "R3 rows 5 and 9",
              {61'd0, hit_vec[300], hit_vec[9], hit_vec[5]}, 64'd3);

        // R6 non-search commands hold results
        issue(3'd1, 9'd5, '0);
        issue(3'd2, 9'd200, 64'h1234);
        issue(3'd4, '0, 64'h0);
        issue(3'd7, '0, '0);
        check(hit_any && hit_addr == 9'd5 && hit_vec[9], "R6 results held",
              {55'd0, hit_addr}, 64'd5);

        // R7 write and match in one cycle sees old contents of row 9
        issue(3'd4, '0, 64'hDEAD_BEEF_0000_2222);
        issue(3'd5, '0, 64'hFFFF_FFFF_FFFF_FFFF);
        issue(3'd6, 9'd9, 64'h5555_5555_5555_5555);
        check(hit_any && hit_addr == 9'd9, "R7 old contents used",
              {55'd0, hit_addr}, 64'd9);
        issue(3'd3, '0, '0);
        check(!hit_any, "R7 new contents stored", {63'd0, hit_any}, 64'd0);
        issue(3'd1, 9'd9, '0);
        check(rd_data == 64'h5555_5555_5555_5555, "R7 read new word", rd_data,
              64'h5555_5555_5555_5555);

        // R9 mask load narrows the compare
        search(64'h0000_0000_0000_1234, 64'h0000_0000_0000_FFFF);
        check(hit_any && hit_addr == 9'd200, "R9 loaded key and mask",
              {55'd0, hit_addr}, 64'd200);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule